// File: doc/BRIEF.md
# Per-Priority Trap Enable Bank

This block keeps one trap-enable mask register for every execution priority level and carries out the two operations that change them. In the set operation, a mask operand is ORed into the register of one chosen priority. In the clear operation, every bit that is set in the operand is removed from that register. The priority is chosen by an operand, not by the priority the processor is running at. Both operations hand back the mask as it stood before the change, so software can restore it later.

Each register is nominally 32 bits wide, but only the lower half-word holds enable bits. The upper half always reads as zero, and operand bits in that half have no effect. All masks are exported together to the trap detection logic. The load-trap and store-trap enables are also brought out as dedicated per-priority outputs. A separate read port returns any priority's mask to other logic.

The operation strobe is a plain control pin and is accepted in every cycle. There is no back-pressure, because each update finishes in one cycle. In the default configuration there are two priorities: 0 is high and 1 is low.

Top module: `trap_enable_bank`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and after it is released, every priority's mask is zero.
- R2: When `op_valid`=1 and `op_set`=1, the register of priority `op_prio` becomes its old value ORed with `op_mask[15:0]`.
- R3: When `op_valid`=1 and `op_set`=0, the register of priority `op_prio` becomes its old value ANDed with the complement of `op_mask[15:0]`.
- R4: `op_result` always shows the current mask of priority `op_prio`, zero-extended, with no register in the path. During a strobe it therefore shows the value before the update. The new value is visible from the cycle after the strobe.
- R5: An operation never changes the mask of any priority other than `op_prio`.
- R6: Bits [31:16] of `op_mask` have no effect, and bits [31:16] of `op_result` and `rd_mask` are always zero.
- R7: When `op_valid`=0, no mask changes, whatever the other operand pins hold.
- R8: `rd_mask` shows the current mask of priority `rd_prio`, zero-extended, with no register in the path.
- R9: `en_bits[p*16 +: 16]` carries the current mask of priority p.
- R10: `ldtrap_en[p]` equals bit 12 of priority p's mask, and `sttrap_en[p]` equals bit 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_set | input | 1 | 1 = set (OR), 0 = clear (AND-NOT) |
| op_mask | input | 32 | Mask operand; only [15:0] used |
| op_prio | input | 1 | Priority whose mask is operated on |
| op_result | output | 32 | Pre-update mask of `op_prio` |
| rd_prio | input | 1 | Priority selected for the read port |
| rd_mask | output | 32 | Mask of `rd_prio` |
| en_bits | output | 32 | Concatenated masks of all priorities |
| ldtrap_en | output | 2 | Load-trap enable, one per priority |
| sttrap_en | output | 2 | Store-trap enable, one per priority |

## Verification
The bench runs back-to-back set and clear operations on the same priority. A design that returned the updated value, or that lagged by a cycle, would report the wrong result on the second operation. Some operands carry upper-half bits: a design that stored them would leak non-zero upper bits or stray enables. A strobe held low with a full mask loaded must leave the target unchanged. Operations on one priority must leave the other intact, which catches a design that decodes `op_prio` wrongly or writes every register.

// File: rtl/trap_en_pkg.sv
package trap_en_pkg;

  // Operation kind carried by op_set
  typedef enum logic {
    TE_CLEAR = 1'b0,
    TE_SET   = 1'b1
  } te_op_e;

  // Default bit positions of named trap enables within a mask
  localparam int unsigned TE_POS_LOAD  = 12;
  localparam int unsigned TE_POS_STORE = 13;

  function automatic logic [15:0] te_apply(input logic [15:0] cur,
                                           input logic [15:0] opnd,
                                           input te_op_e      kind);
    return (kind == TE_SET) ? (cur | opnd) : (cur & ~opnd);
  endfunction

endpackage

// File: rtl/trap_mask_reg.sv
module trap_mask_reg
  import trap_en_pkg::*;
#(
  parameter int unsigned MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  te_op_e            kind,
  input  logic [MASK_W-1:0] opnd,
  output logic [MASK_W-1:0] q
);

  logic [MASK_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) begin
      if (kind == TE_SET) nxt = q | opnd;
      else                nxt = q & ~opnd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == TE_SET) |=> ((q & $past(opnd)) == $past(opnd)) &&
                                  ((q & ~$past(opnd)) == ($past(q) & ~$past(opnd))));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == TE_CLEAR) |=> ((q & $past(opnd)) == '0) &&
                                    ((q & ~$past(opnd)) == ($past(q) & ~$past(opnd))));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/trap_mask_sel.sv
module trap_mask_sel #(
  parameter int unsigned NUM_PRIO = 2,
  parameter int unsigned MASK_W   = 16,
  parameter int unsigned PRIO_W   = 1
) (
  input  logic [NUM_PRIO-1:0][MASK_W-1:0] masks,
  input  logic [PRIO_W-1:0]               sel,
  output logic [MASK_W-1:0]               out
);

  always_comb begin
    out = '0;
    for (int i = 0; i < NUM_PRIO; i++) begin
      if (sel == PRIO_W'(i)) out = masks[i];
    end
  end

endmodule

// File: rtl/trap_enable_bank.sv
module trap_enable_bank
  import trap_en_pkg::*;
#(
  parameter int unsigned NUM_PRIO  = 2,
  parameter int unsigned REG_W     = 32,
  parameter int unsigned MASK_W    = 16,
  parameter int unsigned LOAD_POS  = TE_POS_LOAD,
  parameter int unsigned STORE_POS = TE_POS_STORE,
  localparam int unsigned PRIO_W   = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_valid,
  input  logic                       op_set,
  input  logic [REG_W-1:0]           op_mask,
  input  logic [PRIO_W-1:0]          op_prio,
  output logic [REG_W-1:0]           op_result,
  input  logic [PRIO_W-1:0]          rd_prio,
  output logic [REG_W-1:0]           rd_mask,
  output logic [NUM_PRIO*MASK_W-1:0] en_bits,
  output logic [NUM_PRIO-1:0]        ldtrap_en,
  output logic [NUM_PRIO-1:0]        sttrap_en
);

  localparam int unsigned PAD_W = REG_W - MASK_W;

  logic [NUM_PRIO-1:0][MASK_W-1:0] masks;
  logic [MASK_W-1:0]               opnd_lo;
  logic [MASK_W-1:0]               op_sel;
  logic [MASK_W-1:0]               rd_sel;
  te_op_e                          kind;

  assign opnd_lo = op_mask[MASK_W-1:0];
  assign kind    = te_op_e'(op_set);

  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
    trap_mask_reg #(.MASK_W(MASK_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (op_valid && (op_prio == PRIO_W'(p))),
      .kind  (kind),
      .opnd  (opnd_lo),
      .q     (masks[p])
    );
    assign en_bits[p*MASK_W +: MASK_W] = masks[p];
    assign ldtrap_en[p] = masks[p][LOAD_POS];
    assign sttrap_en[p] = masks[p][STORE_POS];
  end

  trap_mask_sel #(.NUM_PRIO(NUM_PRIO), .MASK_W(MASK_W), .PRIO_W(PRIO_W)) u_op_sel (
    .masks (masks),
    .sel   (op_prio),
    .out   (op_sel)
  );

  trap_mask_sel #(.NUM_PRIO(NUM_PRIO), .MASK_W(MASK_W), .PRIO_W(PRIO_W)) u_rd_sel (
    .masks (masks),
    .sel   (rd_prio),
    .out   (rd_sel)
  );

  assign op_result = {{PAD_W{1'b0}}, op_sel};
  assign rd_mask   = {{PAD_W{1'b0}}, rd_sel};

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_result[REG_W-1:MASK_W] == '0) && (rd_mask[REG_W-1:MASK_W] == '0));

  // R4
  result_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_set && rd_prio == op_prio) |=>
      ((rd_mask & $past(op_result)) == $past(op_result)));

endmodule

// File: tb/test_trap_enable_bank.sv
module test_trap_enable_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_set = 1'b0;
  logic [31:0] op_mask = '0;
  logic        op_prio = 1'b0;
  logic [31:0] op_result;
  logic        rd_prio = 1'b0;
  logic [31:0] rd_mask;
  logic [31:0] en_bits;
  logic [1:0]  ldtrap_en;
  logic [1:0]  sttrap_en;

  int errors = 0;
  int checks = 0;
  logic [15:0] model [2];

  always #10 clk = ~clk;

  trap_enable_bank i_trap_enable_bank (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_set(op_set),
    .op_mask(op_mask), .op_prio(op_prio), .op_result(op_result),
    .rd_prio(rd_prio), .rd_mask(rd_mask), .en_bits(en_bits),
    .ldtrap_en(ldtrap_en), .sttrap_en(sttrap_en)
  );

  // {valid, set, prio, mask[31:0], expected op_result[31:0]}
  localparam int NV = 9;
  localparam logic [66:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 32'h0000_00F0, 32'h0000_0000},
    {1'b1, 1'b1, 1'b1, 32'hFFFF_3000, 32'h0000_0000},
    {1'b1, 1'b1, 1'b0, 32'h0000_0F0F, 32'h0000_00F0},
    {1'b1, 1'b0, 1'b0, 32'h0000_0030, 32'h0000_0FFF},
    {1'b0, 1'b1, 1'b1, 32'h0000_FFFF, 32'h0000_3000},
    {1'b1, 1'b0, 1'b1, 32'hABCD_1000, 32'h0000_3000},
    {1'b1, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0FCF},
    {1'b1, 1'b1, 1'b1, 32'h0000_8001, 32'h0000_2000},
    {1'b1, 1'b1, 1'b0, 32'h0000_2000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reads(input string req);
    for (int p = 0; p < 2; p++) begin
      rd_prio = p[0];
      #1;
      chk(req, rd_mask, {16'h0, model[p]});
    end
    chk({req, " en_bits"}, en_bits, {model[1], model[0]});
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model[0] = '0;
    model[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: masks zero during reset
    check_reads("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reads("R1 after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_valid = VEC[i][66];
      op_set   = VEC[i][65];
      op_prio  = VEC[i][64];
      op_mask  = VEC[i][63:32];
      #2;
      // R4: pre-update value, zero-extended (R6 upper half)
      chk($sformatf("R4 vec%0d op_result", i), op_result, VEC[i][31:0]);
      if (VEC[i][66]) begin
        if (VEC[i][65]) model[VEC[i][64]] = model[VEC[i][64]] | VEC[i][47:32];
        else            model[VEC[i][64]] = model[VEC[i][64]] & ~VEC[i][47:32];
      end
      @(posedge clk);
      #1;
      op_valid = 1'b0;
      // R2 R3 R5 R7 R8 R9: state after the edge
      check_reads($sformatf("R2/R3/R5/R7 vec%0d R8", i));
    end

    // R10: p0 = 2000, p1 = A001 -> store bits set, load bits clear
    chk("R10 ldtrap", {30'h0, ldtrap_en}, 32'h0);
    chk("R10 sttrap", {30'h0, sttrap_en}, 32'h3);
    @(negedge clk);
    op_valid = 1'b1; op_set = 1'b1; op_prio = 1'b1; op_mask = 32'h0000_1000;
    @(negedge clk);
    op_valid = 1'b0;
    model[1] = model[1] | 16'h1000;
    chk("R10 ldtrap after set", {30'h0, ldtrap_en}, 32'h2);
    chk("R4 new value next cycle", op_result, 32'h0000_B001);

    // R6: upper operand bits only -> no change
    op_valid = 1'b1; op_set = 1'b1; op_prio = 1'b0; op_mask = 32'hFFFF_0000;
    @(negedge clk);
    op_valid = 1'b0;
    check_reads("R6 upper-only operand");

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model[0] = '0;
    model[1] = '0;
    check_reads("R1 mid-run reset");
    chk("R1 R10 exports", {28'h0, ldtrap_en, sttrap_en}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule